// File: doc/BRIEF.md
# Two-Stage UART Rate Generator

This block produces the two timing enables that a UART needs: a receiver bit-sample strobe and a baud strobe. Both come from one system clock. The first stage takes as its input either every clock cycle or one cycle in eight, depending on a source-select pin. It divides that input by a 16-bit sample divisor to make the sample strobe. The second stage counts sample strobes and divides them by (baud divisor + 1) to make the baud strobe.

Both divisors are loaded through a small write port. A sample divisor of zero turns off both strobes. The baud divisor has a lower limit: a write with a value below four is dropped, and the register keeps its old value. A write to either divisor restarts the counter of that stage, so the new rate takes effect at once. Both strobes are one-clock pulses, and a baud strobe always falls in the same cycle as a sample strobe.

Top module: `rate_gen_top`

## Requirements
- R1: After reset the sample divisor is 651 and the baud divisor is 15. With src_div8 low, sample strobes are then 651 cycles apart and baud strobes 10416 cycles apart.
- R2: With src_div8 low and a sample divisor D from 1 to 65535, sample_stb pulses exactly once every D clock cycles.
- R3: While the sample divisor is 0, neither sample_stb nor baud_stb is ever asserted.
- R4: With sample divisor D and baud divisor B, baud_stb pulses exactly once every (B+1)*D input ticks.
- R5: A baud-divisor write (cfg_sel=1) whose cfg_wdata[7:0] is below 4 leaves the baud divisor and the baud period unchanged. A write of 4 or more loads cfg_wdata[7:0].
- R6: With src_div8 high, one input tick occurs every 8 clock cycles, so the sample strobes are 8*D cycles apart.
- R7: Both strobes are single-cycle pulses while the baud divisor is 4 or more, and baud_stb is asserted only in a cycle where sample_stb is asserted.
- R8: A sample-divisor write (cfg_sel=0) restarts the first-stage count. With src_div8 low, the first sample strobe after a write of D appears D cycles after the write edge, whatever the old count was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Divisor write strobe |
| cfg_sel | input | 1 | Write target: 0 sample divisor, 1 baud divisor |
| cfg_wdata | input | 16 | Write data; the baud divisor takes bits [7:0] |
| src_div8 | input | 1 | Input tick source: 0 every clock, 1 one clock in eight |
| sample_stb | output | 1 | Bit-sample strobe, one cycle wide |
| baud_stb | output | 1 | Baud strobe, one cycle wide |

## Verification
The checker assumes that src_div8 changes only between measurements and not in the middle of a strobe pair. The bench holds it steady from a divisor write until the measurement that follows is finished. The single-pulse property also assumes a baud divisor of 4 or more, which the register guard itself enforces.

Random divisor pairs are kept small, so that each pair runs to several whole baud periods. Directed cases cover the reset rates, the divisor value zero, the guard values 3 and 4, and a restart in the middle of a count.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
   localparam int unsigned SMP_W_DEF    = 16;
   localparam int unsigned BAUD_W_DEF   = 8;
   localparam int unsigned PREDIV_DEF   = 8;
   localparam int unsigned BAUD_MIN_DEF = 4;
   localparam int unsigned SMP_RST_DEF  = 651;
   localparam int unsigned BAUD_RST_DEF = 15;

   typedef enum logic {
      TGT_SAMPLE = 1'b0,
      TGT_BAUD   = 1'b1
   } cfg_target_e;
endpackage

// File: rtl/rate_cfg_regs.sv
module rate_cfg_regs #(
   parameter int unsigned SMP_W    = 16,
   parameter int unsigned BAUD_W   = 8,
   parameter int unsigned BAUD_MIN = 4,
   parameter int unsigned SMP_RST  = 651,
   parameter int unsigned BAUD_RST = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [SMP_W-1:0]  cfg_wdata,
   output logic [SMP_W-1:0]  smp_div,
   output logic [BAUD_W-1:0] bd_div,
   output logic              smp_load,
   output logic              bd_load
);
   import rate_gen_pkg::*;

   localparam logic [SMP_W-1:0]  SMP_INIT  = SMP_W'(SMP_RST);
   localparam logic [BAUD_W-1:0] BAUD_INIT = BAUD_W'(BAUD_RST);
   localparam logic [BAUD_W-1:0] BAUD_LOW  = BAUD_W'(BAUD_MIN);

   logic [BAUD_W-1:0] bd_wval;
   logic              bd_ok;

   assign bd_wval  = cfg_wdata[BAUD_W-1:0];
   assign bd_ok    = (bd_wval >= BAUD_LOW);
   assign smp_load = cfg_we && (cfg_target_e'(cfg_sel) == TGT_SAMPLE);
   assign bd_load  = cfg_we && (cfg_target_e'(cfg_sel) == TGT_BAUD) && bd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_div <= SMP_INIT;
         bd_div  <= BAUD_INIT;
      end else begin
         if (smp_load) smp_div <= cfg_wdata;
         if (bd_load)  bd_div  <= bd_wval;
      end
   end
endmodule

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
   parameter int unsigned RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_div,
   output logic tick
);
   generate
      if (RATIO > 1) begin : g_div
         localparam int unsigned PW = $clog2(RATIO);
         localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
         logic [PW-1:0] pcnt;
         logic          pwrap;

         assign pwrap = (pcnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pcnt <= '0;
            else if (pwrap)  pcnt <= '0;
            else             pcnt <= pcnt + 1'b1;
         end

         assign tick = use_div ? pwrap : 1'b1;
      end else begin : g_nodiv
         assign tick = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/rate_stage.sv
module rate_stage #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload,
   input  logic         adv,
   input  logic         active,
   input  logic [W-1:0] term,
   output logic         wrap
);
   logic [W-1:0] cnt;

   assign wrap = adv && active && (cnt >= term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (reload)       cnt <= '0;
      else if (wrap)         cnt <= '0;
      else if (adv && active) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rate_gen_top.sv
module rate_gen_top #(
   parameter int unsigned SMP_W    = rate_gen_pkg::SMP_W_DEF,
   parameter int unsigned BAUD_W   = rate_gen_pkg::BAUD_W_DEF,
   parameter int unsigned PREDIV   = rate_gen_pkg::PREDIV_DEF,
   parameter int unsigned BAUD_MIN = rate_gen_pkg::BAUD_MIN_DEF,
   parameter int unsigned SMP_RST  = rate_gen_pkg::SMP_RST_DEF,
   parameter int unsigned BAUD_RST = rate_gen_pkg::BAUD_RST_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [SMP_W-1:0] cfg_wdata,
   input  logic             src_div8,
   output logic             sample_stb,
   output logic             baud_stb
);
   generate
      if (BAUD_W > SMP_W) begin : g_bad_w
         $error("baud divisor wider than write data");
      end
      if (PREDIV < 1) begin : g_bad_pre
         $error("prescale ratio must be at least 1");
      end
      if (BAUD_RST < BAUD_MIN || BAUD_RST >= (1 << BAUD_W)) begin : g_bad_brst
         $error("baud divisor reset value out of range");
      end
      if (SMP_RST >= (1 << SMP_W)) begin : g_bad_srst
         $error("sample divisor reset value out of range");
      end
   endgenerate

   logic [SMP_W-1:0]  smp_div;
   logic [BAUD_W-1:0] bd_div;
   logic              smp_load;
   logic              bd_load;
   logic              in_tick;
   logic              smp_on;
   logic [SMP_W-1:0]  smp_term;

   rate_cfg_regs #(
      .SMP_W(SMP_W), .BAUD_W(BAUD_W), .BAUD_MIN(BAUD_MIN),
      .SMP_RST(SMP_RST), .BAUD_RST(BAUD_RST)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .smp_div(smp_div), .bd_div(bd_div),
      .smp_load(smp_load), .bd_load(bd_load)
   );

   rate_prescaler #(.RATIO(PREDIV)) i_pre (
      .clk(clk), .rst_n(rst_n), .use_div(src_div8), .tick(in_tick)
   );

   assign smp_on   = (smp_div != '0);
   assign smp_term = smp_div - 1'b1;

   rate_stage #(.W(SMP_W)) i_smp (
      .clk(clk), .rst_n(rst_n), .reload(smp_load), .adv(in_tick),
      .active(smp_on), .term(smp_term), .wrap(sample_stb)
   );

   rate_stage #(.W(BAUD_W)) i_baud (
      .clk(clk), .rst_n(rst_n), .reload(bd_load), .adv(sample_stb),
      .active(1'b1), .term(bd_div), .wrap(baud_stb)
   );
endmodule

// File: rtl/rate_gen_chk.sv
module rate_gen_chk #(
   parameter int unsigned SMP_W    = 16,
   parameter int unsigned BAUD_W   = 8,
   parameter int unsigned BAUD_MIN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              cfg_sel,
   input logic [SMP_W-1:0]  cfg_wdata,
   input logic              src_div8,
   input logic              sample_stb,
   input logic              baud_stb,
   input logic [SMP_W-1:0]  smp_div,
   input logic [BAUD_W-1:0] bd_div
);
   // R7
   baud_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      baud_stb |-> sample_stb);

   // R3
   stopped_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_div == '0) |-> (!sample_stb && !baud_stb));

   // R5
   low_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel && (cfg_wdata[BAUD_W-1:0] < BAUD_W'(BAUD_MIN)))
      |=> $stable(bd_div));

   // R5
   good_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel && (cfg_wdata[BAUD_W-1:0] >= BAUD_W'(BAUD_MIN)))
      |=> (bd_div == $past(cfg_wdata[BAUD_W-1:0])));

   // R2
   unit_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_div8 && smp_div == SMP_W'(1)) |-> sample_stb);

   // R6
   slow_src_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_div8 && sample_stb) |=> (!src_div8 || !sample_stb));

   // R7
   baud_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      baud_stb |=> !baud_stb);
endmodule

bind rate_gen_top rate_gen_chk #(
   .SMP_W(SMP_W), .BAUD_W(BAUD_W), .BAUD_MIN(BAUD_MIN)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
   .cfg_wdata(cfg_wdata), .src_div8(src_div8), .sample_stb(sample_stb),
   .baud_stb(baud_stb), .smp_div(smp_div), .bd_div(bd_div)
);

// File: tb/test_rate_gen_top.sv
`timescale 1ns/1ps
module test_rate_gen_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        src_div8 = 1'b0;
   logic        sample_stb;
   logic        baud_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rate_gen_top i_rate_gen_top (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .src_div8(src_div8),
      .sample_stb(sample_stb), .baud_stb(baud_stb)
   );

   function automatic int smp_period(input int d, input bit slow);
      return slow ? 8 * d : d;
   endfunction

   function automatic int baud_period(input int d, input int b, input bit slow);
      return (b + 1) * smp_period(d, slow);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 16'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic meas(input bit use_baud, input int per, input int k, input string req);
      bit found = 1'b0;
      int cnt = 0;
      bit last = 1'b0;
      bit bad7 = 1'b0;
      bit prev = 1'b0;
      bit s;
      for (int i = 0; i < 2 * per + 20 && !found; i++) begin
         @(negedge clk);
         if (use_baud ? baud_stb : sample_stb) found = 1'b1;
      end
      check(found, req, 0, 1);
      if (found) begin
         for (int i = 1; i <= per * k; i++) begin
            @(negedge clk);
            s = use_baud ? baud_stb : sample_stb;
            if (s) cnt++;
            if (baud_stb && !sample_stb) bad7 = 1'b1;
            if (use_baud && s && prev) bad7 = 1'b1;
            prev = s;
            if (i == per * k) last = s;
         end
         check(cnt == k && last, req, cnt, k);
         // R7: baud pulse only together with a sample pulse, one cycle wide
         check(!bad7, "R7", int'(bad7), 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int d, b;
      bit sl;
      int cnt;
      void'($urandom(32'h5a17));
      repeat (3) @(negedge clk);
      // R1: no strobes while held in reset
      check(!sample_stb && !baud_stb, "R1", int'(sample_stb), 0);
      rst_n = 1'b1;

      // R1: reset rates
      meas(1'b0, 651, 3, "R1");
      meas(1'b1, 10416, 1, "R1");

      // R2: direct source, several divisors
      wr(1'b1, 4);
      wr(1'b0, 1);   meas(1'b0, 1, 20, "R2");
      wr(1'b0, 2);   meas(1'b0, 2, 10, "R2");
      wr(1'b0, 37);  meas(1'b0, 37, 4, "R2");
      // R4: baud period with minimum baud divisor
      meas(1'b1, baud_period(37, 4, 1'b0), 2, "R4");

      // R8: restart mid-count
      wr(1'b0, 900);
      repeat (123) @(negedge clk);
      wr(1'b0, 5);
      cnt = 0;
      if (sample_stb) cnt++;
      for (int i = 1; i <= 3; i++) begin
         @(negedge clk);
         if (sample_stb) cnt++;
      end
      check(cnt == 0, "R8", cnt, 0);
      @(negedge clk);
      check(sample_stb == 1'b1, "R8", int'(sample_stb), 1);

      // R5: write below 4 ignored, 4 and above accepted
      wr(1'b1, 6);
      wr(1'b1, 3);
      meas(1'b1, baud_period(5, 6, 1'b0), 2, "R5");
      wr(1'b1, 0);
      meas(1'b1, baud_period(5, 6, 1'b0), 1, "R5");
      wr(1'b1, 255);
      wr(1'b0, 2);
      meas(1'b1, baud_period(2, 255, 1'b0), 1, "R5");

      // R6: predivided source
      src_div8 = 1'b1;
      wr(1'b1, 4);
      wr(1'b0, 3);
      meas(1'b0, smp_period(3, 1'b1), 4, "R6");
      meas(1'b1, baud_period(3, 4, 1'b1), 2, "R6");
      src_div8 = 1'b0;

      // R3: divisor zero stops both strobes
      wr(1'b0, 0);
      cnt = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (sample_stb || baud_stb) cnt++;
      end
      check(cnt == 0, "R3", cnt, 0);

      // R4: random divisor pairs
      for (int n = 0; n < 6; n++) begin
         d  = 1 + int'($urandom % 24);
         b  = 4 + int'($urandom % 9);
         sl = 1'($urandom % 2);
         src_div8 = sl;
         wr(1'b1, b);
         wr(1'b0, d);
         meas(1'b0, smp_period(d, sl), 3, sl ? "R6" : "R2");
         meas(1'b1, baud_period(d, b, sl), 2, "R4");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule